// File: doc/BRIEF.md
# CPU Programmer Register Set

This block keeps the register state that software sees in a 16-bit processor. It has eight general registers, a program counter, a stack pointer and a status word. Two combinational read ports serve operand fetch, and one synchronous write port takes results. The instruction sequencer drives the load, step and flag-update strobes. The block does not decode instructions.

General register 0 is not storage. It always reads as zero, and a write to it is lost, so software can use it as a zero source and as a discard target. The status word holds four condition flags in its low nibble and an interrupt-enable bit above them. Each flag has its own update enable, so one result can change any subset of the flags. The program counter and stack pointer each take a load and a step. A load wins over a step in the same cycle.

Top module: `cpu_regset`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every general register, the program counter, the stack pointer and the status word to zero.
- R2: Reading general register 0 on either read port returns 0x0000.
- R3: A write addressed to general register 0 is discarded. Register 0 still reads zero, and no other register changes.
- R4: A write to register 1..7 appears on both read ports from the cycle after the write edge. A read of the same register in the write cycle returns the old value.
- R5: The program counter takes pcLoadVal when pcLoad is high, or else adds 1 (wrapping 0xFFFF to 0x0000) when pcInc is high, or else holds. Load wins over increment.
- R6: The stack pointer takes spLoadVal when spLoad is high. Otherwise it adds 1 when only spInc is high and subtracts 1 when only spDec is high, with 16-bit wrap. It holds when both or neither are high.
- R7: The status word bits 15..5 always read as zero. Bit 4 is the interrupt enable, and bits 3, 2, 1, 0 hold Z, N, C, V.
- R8: flagEn[i] high loads flagIn[i] into status bit i (i = 0..3: V, C, N, Z). A flag whose enable is low keeps its value.
- R9: The interrupt-enable bit loads ieIn only when ieWrEn is high. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 3 | Read port A register address |
| rdAddrB | input | 3 | Read port B register address |
| rdDataA | output | 16 | Read port A data, combinational |
| rdDataB | output | 16 | Read port B data, combinational |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 3 | Write register address |
| wrData | input | 16 | Write data |
| pcLoad | input | 1 | Load program counter |
| pcInc | input | 1 | Increment program counter |
| pcLoadVal | input | 16 | Program counter load value |
| pcOut | output | 16 | Program counter |
| spLoad | input | 1 | Load stack pointer |
| spInc | input | 1 | Increment stack pointer |
| spDec | input | 1 | Decrement stack pointer |
| spLoadVal | input | 16 | Stack pointer load value |
| spOut | output | 16 | Stack pointer |
| flagEn | input | 4 | Per-flag update enables (3=Z, 2=N, 1=C, 0=V) |
| flagIn | input | 4 | New flag values, same bit order |
| ieWrEn | input | 1 | Interrupt-enable write strobe |
| ieIn | input | 1 | New interrupt-enable value |
| psrOut | output | 16 | Status word |

## Verification
The assertions assume that every strobe input is a known 0 or 1 at each rising edge. They also assume that rst is held high for at least one edge before any result matters. The stimulus asserts reset first, and every random cycle draws each strobe and field as a full-width value. The random draws include simultaneous load and step requests, and inc with dec together, so the priority assertions see every combination. Occasional mid-run resets check the clearing path in the middle of traffic.

// File: rtl/regset_pkg.sv
package regset_pkg;
  localparam int FLAG_N = 4;

  typedef struct packed {
    logic              pcLd;
    logic              pcInc;
    logic              spLd;
    logic              spInc;
    logic              spDec;
    logic              ieWr;
    logic [FLAG_N-1:0] flagWr;
  } regStrobe_t;
endpackage

// File: rtl/regset_ctrl.sv
module regset_ctrl
  import regset_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pcLoad,
  input  logic              pcInc,
  input  logic              spLoad,
  input  logic              spInc,
  input  logic              spDec,
  input  logic              ieWrEn,
  input  logic [FLAG_N-1:0] flagEn,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe.pcLd   = pcLoad;
    strobe.pcInc  = pcInc & ~pcLoad;
    strobe.spLd   = spLoad;
    strobe.spInc  = spInc & ~spDec & ~spLoad;
    strobe.spDec  = spDec & ~spInc & ~spLoad;
    strobe.ieWr   = ieWrEn;
    strobe.flagWr = flagEn;
  end

  AST_PC_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.pcLd, strobe.pcInc})); // R5
  AST_SP_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.spLd, strobe.spInc, strobe.spDec})); // R6
  AST_SP_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    spLoad |-> strobe.spLd && !strobe.spInc && !strobe.spDec); // R6
endmodule

// File: rtl/regset_datapath.sv
module regset_datapath
  import regset_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcLoadVal,
  input  logic [DATA_W-1:0] spLoadVal,
  input  logic [FLAG_N-1:0] flagIn,
  input  logic              ieIn,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] psrOut
);
  localparam int UPPER_W = DATA_W - FLAG_N - 1;

  logic [DATA_W-1:0] gpr [NREG];
  logic [DATA_W-1:0] pcQ, spQ;
  logic [FLAG_N-1:0] flagQ;
  logic              ieQ;

  assign gpr[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)
        gpr[g] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(g))
        gpr[g] <= wrData;
    end
  end

  assign rdDataA = gpr[rdAddrA];
  assign rdDataB = gpr[rdAddrB];

  always_ff @(posedge clk) begin
    if (rst)                pcQ <= '0;
    else if (strobe.pcLd)   pcQ <= pcLoadVal;
    else if (strobe.pcInc)  pcQ <= pcQ + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                spQ <= '0;
    else if (strobe.spLd)   spQ <= spLoadVal;
    else if (strobe.spInc)  spQ <= spQ + DATA_W'(1);
    else if (strobe.spDec)  spQ <= spQ - DATA_W'(1);
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                   flagQ[f] <= 1'b0;
      else if (strobe.flagWr[f]) flagQ[f] <= flagIn[f];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ieQ <= 1'b0;
    else if (strobe.ieWr) ieQ <= ieIn;
  end

  assign pcOut  = pcQ;
  assign spOut  = spQ;
  assign psrOut = {{UPPER_W{1'b0}}, ieQ, flagQ};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> pcOut == '0 && spOut == '0 && psrOut == '0); // R1
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0 |-> rdDataA == '0) and (rdAddrB == '0 |-> rdDataB == '0)); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr != '0 |=> gpr[$past(wrAddr)] == $past(wrData)); // R4
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobe.pcLd |=> pcOut == $past(pcLoadVal)); // R5
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.spLd && !strobe.spInc && !strobe.spDec |=> $stable(spOut)); // R6
  AST_PSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    psrOut[DATA_W-1:FLAG_N+1] == '0); // R7
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    strobe.flagWr == '0 |=> $stable(psrOut[FLAG_N-1:0])); // R8
  AST_IE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !strobe.ieWr |=> $stable(psrOut[FLAG_N])); // R9
endmodule

// File: rtl/cpu_regset.sv
module cpu_regset
  import regset_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  rdAddrA,
  input  logic [2:0]  rdAddrB,
  output logic [15:0] rdDataA,
  output logic [15:0] rdDataB,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        pcLoad,
  input  logic        pcInc,
  input  logic [15:0] pcLoadVal,
  output logic [15:0] pcOut,
  input  logic        spLoad,
  input  logic        spInc,
  input  logic        spDec,
  input  logic [15:0] spLoadVal,
  output logic [15:0] spOut,
  input  logic [3:0]  flagEn,
  input  logic [3:0]  flagIn,
  input  logic        ieWrEn,
  input  logic        ieIn,
  output logic [15:0] psrOut
);
  regStrobe_t strobe;

  regset_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .pcLoad(pcLoad), .pcInc(pcInc),
    .spLoad(spLoad), .spInc(spInc), .spDec(spDec),
    .ieWrEn(ieWrEn), .flagEn(flagEn),
    .strobe(strobe)
  );

  regset_datapath #(.DATA_W(16), .NREG(8)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pcLoadVal(pcLoadVal), .spLoadVal(spLoadVal),
    .flagIn(flagIn), .ieIn(ieIn),
    .pcOut(pcOut), .spOut(spOut), .psrOut(psrOut)
  );
endmodule

// File: tb/tb_cpu_regset.sv
module tb_cpu_regset;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rdAddrA, rdAddrB, wrAddr;
  logic [15:0] rdDataA, rdDataB, wrData, pcLoadVal, spLoadVal;
  logic [15:0] pcOut, spOut, psrOut;
  logic        wrEn, pcLoad, pcInc, spLoad, spInc, spDec, ieWrEn, ieIn;
  logic [3:0]  flagEn, flagIn;

  int nChecks = 0;
  int nFail   = 0;

  logic [15:0] mReg [8];
  logic [15:0] mPc, mSp;
  logic [3:0]  mFlg;
  logic        mIe;
  logic        wasReset;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regset dut (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pcLoad(pcLoad), .pcInc(pcInc), .pcLoadVal(pcLoadVal), .pcOut(pcOut),
    .spLoad(spLoad), .spInc(spInc), .spDec(spDec), .spLoadVal(spLoadVal), .spOut(spOut),
    .flagEn(flagEn), .flagIn(flagIn), .ieWrEn(ieWrEn), .ieIn(ieIn), .psrOut(psrOut)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nextPc(logic [15:0] cur);
    if (pcLoad) return pcLoadVal;
    if (pcInc)  return cur + 16'd1;
    return cur;
  endfunction

  function automatic logic [15:0] nextSp(logic [15:0] cur);
    if (spLoad)          return spLoadVal;
    if (spInc && !spDec) return cur + 16'd1;
    if (spDec && !spInc) return cur - 16'd1;
    return cur;
  endfunction

  task automatic idle();
    rst = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    pcLoad = 0; pcInc = 0; pcLoadVal = 0;
    spLoad = 0; spInc = 0; spDec = 0; spLoadVal = 0;
    flagEn = 0; flagIn = 0; ieWrEn = 0; ieIn = 0;
  endtask

  // Inputs are set at the falling edge; reads are checked before the rising
  // edge (old contents, R2/R4), state after it at the next falling edge.
  task automatic cycle();
    #1;
    chk(rdAddrA == 0 ? "R2 portA" : (wasReset ? "R1 portA" : "R4 portA"), rdDataA, mReg[rdAddrA]);
    chk(rdAddrB == 0 ? "R2 portB" : (wasReset ? "R1 portB" : "R4 portB"), rdDataB, mReg[rdAddrB]);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 8; i++) mReg[i] = 16'h0;
      mPc = 0; mSp = 0; mFlg = 0; mIe = 0;
    end else begin
      if (wrEn && wrAddr != 0) mReg[wrAddr] = wrData;
      mPc = nextPc(mPc);
      mSp = nextSp(mSp);
      for (int f = 0; f < 4; f++) if (flagEn[f]) mFlg[f] = flagIn[f];
      if (ieWrEn) mIe = ieIn;
    end
    wasReset = rst;
    @(negedge clk);
    chk(rst ? "R1 pc" : "R5 pc", pcOut, mPc);
    chk(rst ? "R1 sp" : "R6 sp", spOut, mSp);
    chk("R7 upper", {5'd0, psrOut[15:5]}, 16'h0);
    chk(rst ? "R1 flags" : "R8 flags", {12'd0, psrOut[3:0]}, {12'd0, mFlg});
    chk("R9 ie", {15'd0, psrOut[4]}, {15'd0, mIe});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mReg[i] = 16'hxxxx;
    mPc = 'x; mSp = 'x; mFlg = 'x; mIe = 'x;
    wasReset = 0;
    idle();
    rdAddrA = 0; rdAddrB = 0;
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mReg[i] = 16'h0;
    mPc = 0; mSp = 0; mFlg = 0; mIe = 0;
    @(negedge clk);
    idle();
    // R1: all cleared after reset, read every register through the ports
    for (int i = 0; i < 8; i++) begin
      rdAddrA = 3'(i); rdAddrB = 3'(7 - i);
      #1;
      chk("R1 rdA", rdDataA, 16'h0);
      chk("R1 rdB", rdDataB, 16'h0);
    end
    chk("R1 pc", pcOut, 16'h0);
    chk("R1 sp", spOut, 16'h0);
    chk("R1 psr", psrOut, 16'h0);
    @(negedge clk);

    // R4: fill registers; same-cycle read of the target returns old value
    for (int i = 1; i < 8; i++) begin
      wrEn = 1; wrAddr = 3'(i); wrData = 16'h1111 * 16'(i);
      rdAddrA = 3'(i); rdAddrB = 3'(i);
      cycle();
    end
    idle();
    // R3: write to register 0 is lost, neighbours unchanged
    wrEn = 1; wrAddr = 0; wrData = 16'hBEEF; rdAddrA = 0; rdAddrB = 1;
    cycle();
    idle();
    for (int i = 0; i < 8; i++) begin
      rdAddrA = 3'(i); rdAddrB = 0;
      #1;
      chk("R3 after r0 write", rdDataA, i == 0 ? 16'h0 : 16'h1111 * 16'(i));
      chk("R3 r0 still zero", rdDataB, 16'h0);
    end
    @(negedge clk);

    // R5: load beats increment; wrap at top
    pcLoad = 1; pcInc = 1; pcLoadVal = 16'hFFFF; cycle();
    pcLoad = 0; pcInc = 1; cycle();
    chk("R5 wrap", pcOut, 16'h0000);
    idle();
    // R6: dec from zero wraps, inc+dec holds, load beats both
    spLoad = 1; spLoadVal = 16'h0000; cycle();
    spLoad = 0; spDec = 1; cycle();
    chk("R6 dec wrap", spOut, 16'hFFFF);
    spInc = 1; spDec = 1; cycle();
    chk("R6 inc+dec hold", spOut, 16'hFFFF);
    spLoad = 1; spLoadVal = 16'h1234; cycle();
    chk("R6 load wins", spOut, 16'h1234);
    idle();
    // R8: update only Z and V, then only C
    flagEn = 4'b1001; flagIn = 4'b1111; cycle();
    chk("R8 Z,V only", {12'd0, psrOut[3:0]}, 16'h0009);
    flagEn = 4'b0010; flagIn = 4'b0000; cycle();
    chk("R8 C only", {12'd0, psrOut[3:0]}, 16'h0009);
    idle();
    // R9: ieIn without strobe is ignored, then written
    ieIn = 1; cycle();
    chk("R9 no strobe", {15'd0, psrOut[4]}, 16'h0);
    ieWrEn = 1; cycle();
    chk("R9 write", {15'd0, psrOut[4]}, 16'h1);
    chk("R7 packing", psrOut, 16'h0019);
    idle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      rst       = ($urandom % 250) == 0;
      rdAddrA   = 3'($urandom); rdAddrB = 3'($urandom);
      wrEn      = 1'($urandom); wrAddr  = 3'($urandom); wrData = 16'($urandom);
      pcLoad    = ($urandom % 4) == 0; pcInc = 1'($urandom); pcLoadVal = 16'($urandom);
      spLoad    = ($urandom % 4) == 0; spInc = 1'($urandom); spDec = 1'($urandom);
      spLoadVal = 16'($urandom);
      flagEn    = 4'($urandom); flagIn = 4'($urandom);
      ieWrEn    = 1'($urandom); ieIn = 1'($urandom);
      cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule